// File: doc/BRIEF.md
# Configuration Base Address Registers

This block holds the three base address registers of a bus configuration header: a 256-byte I/O window, a 256-byte memory window and an expansion-ROM window. A configuration agent reads and writes them as 32-bit words at fixed dword offsets, with per-lane byte enables. Each register has a per-bit write mask, so the bits that give the window size always read back as zero and the bits that give the space type hold fixed values. Enumeration software can therefore size each window by writing all ones and reading the result back.

The size of the ROM window comes from a 3-bit strap. The strap sets how many bits of the ROM size field software may write, and whether the ROM enable exists at all. The strap may change while the block is running, and the masks follow it on the next access. Three registered hit outputs compare a bus address against each programmed base above that window's size. Software uses them to claim accesses.

Top module: `cfg_bar_block`

## Requirements
- R1: After a synchronous reset, every writable bit of the three registers is zero, the ROM enable is clear, and `cfg_rdata` and the three hit outputs are zero.
- R2: The I/O register sits at dword offset 4 (byte 0x10). Bits 31..8 hold the written value, bits 7..1 read as zero, and bit 0 always reads as one.
- R3: The memory register sits at dword offset 5 (byte 0x14). Bits 31..8 hold the written value, and bits 7..0 always read as zero.
- R4: The ROM register sits at dword offset 12 (byte 0x30). Bits 31..18 are writable for every strap code, and bits 10..1 always read as zero.
- R5: For strap code k in 1..5, the ROM window is 2^(12+k) bytes. Bits 11..(11+k) read as zero, bits (12+k)..17 are writable, and bit 0 is a writable enable.
- R6: For strap codes 0, 6 and 7 there is no ROM. Bits 17..11 and the enable (bit 0) read as zero, and `rom_hit` never asserts.
- R7: A write changes only the bits that are writable under the strap at the time of the write. A read masks the stored value with the strap at the time of the read. A write made while the strap is 0 leaves the stored enable unchanged.
- R8: A write updates byte lane n (bits 8n+7..8n) only when `cfg_be[n]` is 1.
- R9: `cfg_rdata` shows the register read one cycle after `cfg_rd`. It is zero in any cycle that follows no read. Offsets other than 4, 5 and 12 read as zero, and writes to them have no effect.
- R10: One cycle after `bus_addr` is presented, `io_hit` is 1 exactly when `bus_addr[31:8]` equals the I/O base. `mem_hit` behaves the same way against the memory base.
- R11: One cycle after `bus_addr` is presented, `rom_hit` is 1 exactly when the strap is in 1..5, the enable is set, and `bus_addr` equals the ROM base on bits 31..(12+k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Dword offset within the header |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| rom_size_sel | input | 3 | ROM window size strap |
| bus_addr | input | 32 | Bus address to decode |
| io_hit | output | 1 | Registered I/O window match |
| mem_hit | output | 1 | Registered memory window match |
| rom_hit | output | 1 | Registered ROM window match |

## Verification
The assertions check on every cycle the fixed low bits returned by each register's read. They also check that read data is zero after an idle cycle, that no ROM hit occurs without a ROM or without the enable, and that the enable cannot change while no ROM is strapped. Other behaviours can only be shown by the bench's scenarios, which a behavioural model compares on every clock: where each strap code puts the writable boundary, that stored bits survive a strap change, byte-lane merging, and hits exactly at and just outside each window edge.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LANES = DW / 8;

  // expand byte enables into a per-bit mask
  function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    m = '0;
    for (int l = 0; l < int'(LANES); l++) m[l*8 +: 8] = {8{be[l]}};
    return m;
  endfunction
endpackage

// File: rtl/rom_size_decode.sv
module rom_size_decode
  import cfgbar_pkg::*;
#(
  parameter int STRAP_W  = 3,
  parameter int FIELD_LO = 11,
  parameter int BASE_LO  = 18,
  parameter int MIN_LOG2 = 13
) (
  input  logic [STRAP_W-1:0] strap,
  output logic               present,
  output logic [DW-1:0]      rom_mask
);
  localparam int MAX_CODE = BASE_LO - MIN_LOG2;

  always_comb begin
    present  = (strap != '0) && (int'(strap) <= MAX_CODE);
    rom_mask = '0;
    for (int i = BASE_LO; i < int'(DW); i++) rom_mask[i] = 1'b1;
    if (present) begin
      rom_mask[0] = 1'b1;
      for (int i = FIELD_LO; i < BASE_LO; i++)
        if (i >= MIN_LOG2 - 1 + int'(strap)) rom_mask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/cfg_bar_field.sv
module cfg_bar_field
  import cfgbar_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    wmask,
  output logic [DW-1:0]    q
);
  logic [DW-1:0] upd;
  assign upd = lane_mask(be) & wmask;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= (q & ~upd) | (wdata & upd);
  end
endmodule

// File: rtl/bar_hit.sv
module bar_hit
  import cfgbar_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] cmp_mask,
  output logic          hit
);
  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= en && (((addr ^ base) & cmp_mask) == '0);
  end
endmodule

// File: rtl/cfg_bar_block.sv
module cfg_bar_block
  import cfgbar_pkg::*;
#(
  parameter int OFS_W        = 6,
  parameter int IO_OFS       = 4,
  parameter int MEM_OFS      = 5,
  parameter int ROM_OFS      = 12,
  parameter int IO_LOG2      = 8,
  parameter int MEM_LOG2     = 8,
  parameter int STRAP_W      = 3,
  parameter int ROM_FIELD_LO = 11,
  parameter int ROM_BASE_LO  = 18,
  parameter int ROM_MIN_LOG2 = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [OFS_W-1:0]   cfg_addr,
  input  logic [LANES-1:0]   cfg_be,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  input  logic [STRAP_W-1:0] rom_size_sel,
  input  logic [DW-1:0]      bus_addr,
  output logic               io_hit,
  output logic               mem_hit,
  output logic               rom_hit
);
  localparam logic [DW-1:0]    IO_WMASK  = {DW{1'b1}} << IO_LOG2;
  localparam logic [DW-1:0]    MEM_WMASK = {DW{1'b1}} << MEM_LOG2;
  localparam logic [DW-1:0]    IO_FIXED  = DW'(1);
  localparam logic [OFS_W-1:0] A_IO      = OFS_W'(IO_OFS);
  localparam logic [OFS_W-1:0] A_MEM     = OFS_W'(MEM_OFS);
  localparam logic [OFS_W-1:0] A_ROM     = OFS_W'(ROM_OFS);
  localparam int               NBAR      = 3;

  logic          rom_present;
  logic [DW-1:0] rom_mask;
  logic [DW-1:0] io_q, mem_q, rom_q;
  logic [DW-1:0] io_val, mem_val, rom_val;

  rom_size_decode #(
    .STRAP_W (STRAP_W), .FIELD_LO(ROM_FIELD_LO),
    .BASE_LO (ROM_BASE_LO), .MIN_LOG2(ROM_MIN_LOG2)
  ) u_dec (
    .strap(rom_size_sel), .present(rom_present), .rom_mask(rom_mask)
  );

  cfg_bar_field u_io (
    .clk(clk), .rst(rst), .we(cfg_wr && cfg_addr == A_IO), .be(cfg_be),
    .wdata(cfg_wdata), .wmask(IO_WMASK), .q(io_q)
  );
  cfg_bar_field u_mem (
    .clk(clk), .rst(rst), .we(cfg_wr && cfg_addr == A_MEM), .be(cfg_be),
    .wdata(cfg_wdata), .wmask(MEM_WMASK), .q(mem_q)
  );
  // ROM writes use the mask of the current strap
  cfg_bar_field u_rom (
    .clk(clk), .rst(rst), .we(cfg_wr && cfg_addr == A_ROM), .be(cfg_be),
    .wdata(cfg_wdata), .wmask(rom_mask), .q(rom_q)
  );

  assign io_val  = (io_q & IO_WMASK) | IO_FIXED;
  assign mem_val = mem_q & MEM_WMASK;
  assign rom_val = rom_q & rom_mask;

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_rd) begin
      case (cfg_addr)
        A_IO:    cfg_rdata <= io_val;
        A_MEM:   cfg_rdata <= mem_val;
        A_ROM:   cfg_rdata <= rom_val;
        default: cfg_rdata <= '0;
      endcase
    end else cfg_rdata <= '0;
  end

  // one address comparator per window
  logic [DW-1:0]   base_a [NBAR];
  logic [DW-1:0]   mask_a [NBAR];
  logic [NBAR-1:0] en_a;
  logic [NBAR-1:0] hit_a;

  assign base_a[0] = io_val;  assign mask_a[0] = IO_WMASK;  assign en_a[0] = 1'b1;
  assign base_a[1] = mem_val; assign mask_a[1] = MEM_WMASK; assign en_a[1] = 1'b1;
  assign base_a[2] = rom_val; assign mask_a[2] = rom_mask & ~DW'(1);
  assign en_a[2]   = rom_val[0];

  for (genvar g = 0; g < NBAR; g++) begin : g_hit
    bar_hit u_hit (
      .clk(clk), .rst(rst), .en(en_a[g]), .addr(bus_addr),
      .base(base_a[g]), .cmp_mask(mask_a[g]), .hit(hit_a[g])
    );
  end

  assign io_hit  = hit_a[0];
  assign mem_hit = hit_a[1];
  assign rom_hit = hit_a[2];

  p_io_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_rd && cfg_addr == A_IO |=> cfg_rdata[IO_LOG2-1:0] == IO_LOG2'(1));
  p_mem_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_rd && cfg_addr == A_MEM |=> cfg_rdata[MEM_LOG2-1:0] == '0);
  p_rom_gap_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_rd && cfg_addr == A_ROM |=> cfg_rdata[ROM_FIELD_LO-1:1] == '0);
  p_no_rom_hit_r6: assert property (@(posedge clk) disable iff (rst)
    !rom_present |=> !rom_hit);
  p_en_locked_r7: assert property (@(posedge clk) disable iff (rst)
    !rom_present && cfg_wr && cfg_addr == A_ROM |=> $stable(rom_q[0]));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> cfg_rdata == '0);
  p_rom_en_r11: assert property (@(posedge clk) disable iff (rst)
    rom_hit |-> $past(rom_present && rom_q[0]));
endmodule

// File: tb/sim_cfg_bar_block.sv
`timescale 1ns/1ps
module sim_cfg_bar_block;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [5:0]  cfg_addr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [2:0]  rom_size_sel = 0;
  logic [31:0] bus_addr = 0;
  logic        io_hit, mem_hit, rom_hit;

  always #4 clk = ~clk;

  cfg_bar_block u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rom_size_sel(rom_size_sel), .bus_addr(bus_addr),
    .io_hit(io_hit), .mem_hit(mem_hit), .rom_hit(rom_hit)
  );

  int    n_chk = 0, n_fail = 0;
  bit    started = 0, done = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [31:0] m_io = 0, m_mem = 0, m_rom = 0;
  logic [31:0] e_rd = 0;
  bit          e_io = 0, e_mem = 0, e_rom = 0;

  function automatic bit has_rom(int s);
    return s >= 1 && s <= 5;
  endfunction

  function automatic bit rom_bit_ok(int s, int i);
    if (i >= 18) return 1;
    if (!has_rom(s)) return 0;
    return (i == 0) || (i >= 12 + s && i <= 17);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_io = 0; m_mem = 0; m_rom = 0; e_rd = 0; e_io = 0; e_mem = 0; e_rom = 0;
    end else begin
      int s;
      s = int'(rom_size_sel);
      e_rd = 0;
      if (cfg_rd) begin
        if (cfg_addr == 4) e_rd = m_io | 32'h1;
        else if (cfg_addr == 5) e_rd = m_mem;
        else if (cfg_addr == 12)
          for (int i = 0; i < 32; i++) e_rd[i] = m_rom[i] & rom_bit_ok(s, i);
      end
      e_io  = (bus_addr[31:8] == m_io[31:8]);
      e_mem = (bus_addr[31:8] == m_mem[31:8]);
      e_rom = has_rom(s) && m_rom[0];
      for (int i = 12 + s; i < 32; i++) if (bus_addr[i] != m_rom[i]) e_rom = 0;
      if (cfg_wr)
        for (int i = 0; i < 32; i++)
          if (cfg_be[i/8]) begin
            if (cfg_addr == 4 && i >= 8) m_io[i] = cfg_wdata[i];
            if (cfg_addr == 5 && i >= 8) m_mem[i] = cfg_wdata[i];
            if (cfg_addr == 12 && rom_bit_ok(s, i)) m_rom[i] = cfg_wdata[i];
          end
    end
  end

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", cur_tag, what, got, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("rdata", cfg_rdata, e_rd);
    chk("io_hit", 32'(io_hit), 32'(e_io));
    chk("mem_hit", 32'(mem_hit), 32'(e_mem));
    chk("rom_hit", 32'(rom_hit), 32'(e_rom));
  end

  task automatic op(bit w, bit r, int a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = w; cfg_rd = r; cfg_addr = a[5:0]; cfg_be = be; cfg_wdata = d;
  endtask
  task automatic wr(int a, logic [3:0] be, logic [31:0] d); op(1, 0, a, be, d); endtask
  task automatic rd(int a); op(0, 1, a, 4'h0, 32'h0); endtask
  task automatic idle(); op(0, 0, 0, 4'h0, 32'h0); endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R1"; rd(4); rd(5); rd(12); idle();
    cur_tag = "R2"; wr(4, 4'hF, 32'hFFFF_FFFF); rd(4); wr(4, 4'hF, 32'h1234_56FE); rd(4);
    cur_tag = "R3"; wr(5, 4'hF, 32'hFFFF_FFFF); rd(5); wr(5, 4'hF, 32'hCAFE_B0FF); rd(5);
    cur_tag = "R4"; rom_size_sel = 0; wr(12, 4'hF, 32'hFFFF_FFFF); rd(12);
    cur_tag = "R6"; rom_size_sel = 6; wr(12, 4'hF, 32'hFFFF_FFFF); rd(12);
    bus_addr = 32'hFFFC_0000; idle(); idle();
    rom_size_sel = 7; rd(12); idle();
    cur_tag = "R5";
    for (int k = 1; k <= 5; k++) begin
      rom_size_sel = 3'(k);
      wr(12, 4'hF, 32'h0); rd(12); wr(12, 4'hF, 32'hFFFF_FFFF); rd(12);
    end
    cur_tag = "R7";
    rom_size_sel = 5; wr(12, 4'hF, 32'h0000_0000); wr(12, 4'hF, 32'hFFFF_FFFF);
    rom_size_sel = 1; rd(12);
    rom_size_sel = 0; wr(12, 4'hF, 32'h0); rd(12);
    rom_size_sel = 5; rd(12);
    cur_tag = "R8";
    wr(4, 4'hF, 32'h0); wr(4, 4'b0100, 32'hAABB_CCDD); rd(4);
    wr(5, 4'hF, 32'h0); wr(5, 4'b1010, 32'h1122_3344); rd(5);
    wr(5, 4'b0001, 32'hFFFF_FFFF); rd(5);
    cur_tag = "R9";
    rd(0); wr(13, 4'hF, 32'hFFFF_FFFF); rd(13); rd(63); idle(); rd(4); idle();
    cur_tag = "R10";
    wr(4, 4'hF, 32'h1234_5600); wr(5, 4'hF, 32'h8000_1000);
    bus_addr = 32'h1234_56AB; idle(); idle();
    bus_addr = 32'h1234_57AB; idle(); idle();
    bus_addr = 32'h8000_10FF; idle(); idle();
    bus_addr = 32'h8000_1100; idle(); idle();
    cur_tag = "R11";
    rom_size_sel = 3; wr(12, 4'hF, 32'hABCD_8001);
    bus_addr = 32'hABCD_FFFF; idle(); idle();
    bus_addr = 32'hABCD_0000; idle(); idle();
    wr(12, 4'h1, 32'h0); bus_addr = 32'hABCD_8123; idle(); idle();
    wr(12, 4'h1, 32'h1); idle(); idle();
    rom_size_sel = 0; idle(); idle();
    rom_size_sel = 5; bus_addr = 32'hABCE_0000; idle(); idle();
    bus_addr = 32'hABCC_0000; idle(); idle();
    idle(); idle();
    finish_run();
  end
endmodule